// File: doc/BRIEF.md
# Flash Page-Mode Burst Reader

This block is the host side of a read path to a parallel NOR-style flash that supports fast page reads. A client hands it a start byte address and a width mode. The block aligns the address down to the start of its page. It enables the device by driving chip enable and output enable low, and holds them low for the whole burst. It spends one full-latency access on the first location of the page. It then walks the in-page address bits through the rest of the page, using the shorter page access time for each step. The page bits of the address never move while the device is enabled.

In word mode a burst returns 8 sixteen-bit words. In byte mode the device's extra lowest address line is stepped as well, and a burst returns 16 bytes on the low half of the data bus. Every datum leaves on a valid/data stream, and the final one is flagged. The two wait counts are parameters. After a burst the enables return high for at least one cycle before the next request can be taken. Requests are accepted only while the block is idle.

Top module: `flash_page_reader`

## Requirements
- R1: After reset, reqReady is 1, flashCeN and flashOeN are 1, and rdValid and rdLast are 0.
- R2: flashWeN is always 1, and flashCeN and flashOeN always carry the same value.
- R3: While flashCeN stays low, flashAddr[ADDR_W-1:3] does not change and equals reqAddr[ADDR_W:4] of the accepted request. Each burst starts at in-page offset 0, with flashAddr[2:0]=0 and flashAm1=0.
- R4: With reqByteMode=0 a burst yields exactly 8 beats, and flashByteN is 1. Beat k reads word address {page, k[2:0]} with flashAm1=0, and rdData is the full bus.
- R5: With reqByteMode=1 a burst yields exactly 16 beats, and flashByteN is 0. Beat k reads flashAddr={page, k[3:1]} with flashAm1=k[0]. rdData carries flashData[7:0] with the upper 8 bits zero.
- R6: If a request is accepted at clock edge A, beat k appears on rdValid right after edge A+FULL_WAIT+k*PAGE_WAIT.
- R7: A request is taken only on an edge where reqReady is 1. reqValid asserted while a burst is running has no effect on the beats, their addresses or their count.
- R8: rdLast is 1 on the final beat of a burst only. In the cycle after it, flashCeN and flashOeN are 1, and reqReady rises one cycle after rdLast.
- R9: Each beat's rdData equals the device contents at that beat's address, sampled at the end of its wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Burst request |
| reqAddr | input | ADDR_W+1 | Start byte address (bit 0 is the byte-select line) |
| reqByteMode | input | 1 | 1 selects byte mode, 0 selects word mode |
| reqReady | output | 1 | Block idle, request taken on this edge |
| flashCeN | output | 1 | Chip enable, active low |
| flashOeN | output | 1 | Output enable, active low |
| flashWeN | output | 1 | Write enable, held high |
| flashByteN | output | 1 | Width select to device, low for byte mode |
| flashAddr | output | ADDR_W | Word address lines |
| flashAm1 | output | 1 | Lowest byte-select address line |
| flashData | input | DATA_W | Data bus from device |
| rdValid | output | 1 | Beat valid |
| rdData | output | DATA_W | Beat data |
| rdLast | output | 1 | Final beat of burst |

## Verification
The assertions assume that the device returns correct data only after the configured full or page wait, and that the reset is held long enough to reach the idle state. They also assume the client keeps reqAddr and reqByteMode steady while reqValid waits for reqReady. The stimulus changes its request inputs only on falling edges. It keeps a request pending until the ready edge, and while a burst runs it either drops reqValid or holds it high with scrambled address and mode values, so that the ignore rule is exercised. The bench device model drives a poison pattern whenever an access has not been given its full wait, and it puts junk on the upper byte lane in byte mode.

// File: rtl/flash_page_pkg.sv
package flash_page_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ACCESS  = 2'd1,
    ST_RECOVER = 2'd2
  } seqState_t;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic load;     // accept request, latch page and mode
    logic capture;  // sample the data bus at the end of a wait
    logic step;     // move to next in-page offset
    logic finish;   // final beat captured
  } seqStrobes_t;

endpackage

// File: rtl/flash_page_ctrl.sv
module flash_page_ctrl
  import flash_page_pkg::*;
#(
  parameter int FULL_WAIT = 6,
  parameter int PAGE_WAIT = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        lastBeat,
  output seqStrobes_t strobes,
  output logic        busActive,
  output logic        reqReady
);

  localparam int MAX_WAIT = (FULL_WAIT > PAGE_WAIT) ? FULL_WAIT : PAGE_WAIT;
  localparam int CNT_W    = (MAX_WAIT < 2) ? 1 : $clog2(MAX_WAIT);
  localparam logic [CNT_W-1:0] FULL_LOAD = CNT_W'(FULL_WAIT - 1);
  localparam logic [CNT_W-1:0] PAGE_LOAD = CNT_W'(PAGE_WAIT - 1);

  seqState_t        state, stateNext;
  logic [CNT_W-1:0] waitCnt, waitCntNext;
  logic             waitDone;

  assign waitDone  = (waitCnt == '0);
  assign busActive = (state == ST_ACCESS);
  assign reqReady  = (state == ST_IDLE);

  always_comb begin
    strobes         = '0;
    strobes.load    = (state == ST_IDLE) && reqValid;
    strobes.capture = (state == ST_ACCESS) && waitDone;
    strobes.step    = strobes.capture && !lastBeat;
    strobes.finish  = strobes.capture && lastBeat;
  end

  always_comb begin
    stateNext   = state;
    waitCntNext = waitCnt;
    unique case (state)
      ST_IDLE: begin
        if (strobes.load) begin
          stateNext   = ST_ACCESS;
          waitCntNext = FULL_LOAD;
        end
      end
      ST_ACCESS: begin
        if (strobes.finish) begin
          stateNext = ST_RECOVER;
        end else if (strobes.step) begin
          waitCntNext = PAGE_LOAD;
        end else begin
          waitCntNext = waitCnt - 1'b1;
        end
      end
      ST_RECOVER: stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
    end else begin
      state   <= stateNext;
      waitCnt <= waitCntNext;
    end
  end

endmodule

// File: rtl/flash_page_dp.sv
module flash_page_dp
  import flash_page_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16,
  parameter int WIDX_W = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  seqStrobes_t              strobes,
  input  logic [ADDR_W-WIDX_W-1:0] pageIn,
  input  logic                     byteModeIn,
  input  logic [DATA_W-1:0]        flashData,
  output logic                     lastBeat,
  output logic [ADDR_W-1:0]        flashAddr,
  output logic                     flashAm1,
  output logic                     flashByteN,
  output logic                     rdValid,
  output logic [DATA_W-1:0]        rdData,
  output logic                     rdLast
);

  localparam int PAGE_W = ADDR_W - WIDX_W;
  localparam int IDX_W  = WIDX_W + 1;      // one extra bit for byte lane
  localparam int HALF_W = DATA_W / 2;

  logic [PAGE_W-1:0] pageReg;
  logic              byteMode;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] laneData;

  // address lines: byte mode shifts the offset up by one, lowest bit on Am1
  always_comb begin
    if (byteMode) begin
      flashAddr = {pageReg, idx[IDX_W-1:1]};
      flashAm1  = idx[0];
      lastBeat  = &idx;
    end else begin
      flashAddr = {pageReg, idx[WIDX_W-1:0]};
      flashAm1  = 1'b0;
      lastBeat  = &idx[WIDX_W-1:0];
    end
  end

  assign flashByteN = !byteMode;

  generate
    if (HALF_W > 0) begin : g_lane
      assign laneData = byteMode ? {{(DATA_W-HALF_W){1'b0}}, flashData[HALF_W-1:0]}
                                 : flashData;
    end else begin : g_nolane
      assign laneData = flashData;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageReg  <= '0;
      byteMode <= 1'b0;
      idx      <= '0;
    end else if (strobes.load) begin
      pageReg  <= pageIn;
      byteMode <= byteModeIn;
      idx      <= '0;
    end else if (strobes.step) begin
      idx      <= idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdLast  <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strobes.capture;
      rdLast  <= strobes.finish;
      if (strobes.capture) rdData <= laneData;
    end
  end

endmodule

// File: rtl/flash_page_reader.sv
module flash_page_reader
  import flash_page_pkg::*;
#(
  parameter int ADDR_W    = 21,
  parameter int DATA_W    = 16,
  parameter int FULL_WAIT = 6,
  parameter int PAGE_WAIT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W:0]   reqAddr,
  input  logic              reqByteMode,
  output logic              reqReady,
  output logic              flashCeN,
  output logic              flashOeN,
  output logic              flashWeN,
  output logic              flashByteN,
  output logic [ADDR_W-1:0] flashAddr,
  output logic              flashAm1,
  input  logic [DATA_W-1:0] flashData,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              rdLast
);

  localparam int WIDX_W = 3;            // word offset bits inside a page
  localparam int OFS_W  = WIDX_W + 1;   // byte offset bits inside a page

  seqStrobes_t strobes;
  logic        busActive;
  logic        lastBeat;
  logic        unusedOffset;

  assign unusedOffset = ^reqAddr[OFS_W-1:0];

  flash_page_ctrl #(
    .FULL_WAIT(FULL_WAIT),
    .PAGE_WAIT(PAGE_WAIT)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .lastBeat (lastBeat),
    .strobes  (strobes),
    .busActive(busActive),
    .reqReady (reqReady)
  );

  flash_page_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .WIDX_W(WIDX_W)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .pageIn    (reqAddr[ADDR_W:OFS_W]),
    .byteModeIn(reqByteMode),
    .flashData (flashData),
    .lastBeat  (lastBeat),
    .flashAddr (flashAddr),
    .flashAm1  (flashAm1),
    .flashByteN(flashByteN),
    .rdValid   (rdValid),
    .rdData    (rdData),
    .rdLast    (rdLast)
  );

  assign flashCeN = !busActive;
  assign flashOeN = !busActive;
  assign flashWeN = 1'b1;

endmodule

// File: rtl/flash_page_reader_chk.sv
module flash_page_reader_chk #(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              flashCeN,
  input logic              flashOeN,
  input logic              flashByteN,
  input logic [ADDR_W-1:0] flashAddr,
  input logic              flashAm1,
  input logic              rdValid,
  input logic [DATA_W-1:0] rdData,
  input logic              rdLast
);

  AST_PAGE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (!flashCeN && $past(!flashCeN)) |-> flashAddr[ADDR_W-1:3] == $past(flashAddr[ADDR_W-1:3])); // R3

  AST_START_OFFSET_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flashCeN) |-> (flashAddr[2:0] == 3'd0 && !flashAm1)); // R3

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (!flashOeN && $past(!flashOeN)) |-> $stable(flashByteN)); // R5

  AST_UPPER_LANE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !flashByteN) |-> rdData[DATA_W-1:DATA_W/2] == '0); // R5

  AST_GAP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    rdLast |-> (flashCeN && flashOeN)); // R8

  AST_LAST_IS_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    rdLast |-> rdValid); // R8

  AST_READY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> flashCeN); // R7

  AST_SAMPLE_ON_BUS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdValid) |-> $past(!flashCeN && !flashOeN)); // R9

endmodule

bind flash_page_reader flash_page_reader_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .reqReady  (reqReady),
  .flashCeN  (flashCeN),
  .flashOeN  (flashOeN),
  .flashByteN(flashByteN),
  .flashAddr (flashAddr),
  .flashAm1  (flashAm1),
  .rdValid   (rdValid),
  .rdData    (rdData),
  .rdLast    (rdLast)
);

// File: tb/sim_flash_page_reader.sv
module sim_flash_page_reader;

  localparam int AW = 21;
  localparam int DW = 16;
  localparam int FW = 6;
  localparam int PW = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [AW:0]   reqAddr = '0;
  logic          reqByteMode = 1'b0;
  logic          reqReady;
  logic          flashCeN, flashOeN, flashWeN, flashByteN, flashAm1;
  logic [AW-1:0] flashAddr;
  logic [DW-1:0] flashData;
  logic          rdValid, rdLast;
  logic [DW-1:0] rdData;

  always #5 clk = ~clk;

  flash_page_reader #(.ADDR_W(AW), .DATA_W(DW), .FULL_WAIT(FW), .PAGE_WAIT(PW)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqByteMode(reqByteMode), .reqReady(reqReady), .flashCeN(flashCeN),
    .flashOeN(flashOeN), .flashWeN(flashWeN), .flashByteN(flashByteN),
    .flashAddr(flashAddr), .flashAm1(flashAm1), .flashData(flashData),
    .rdValid(rdValid), .rdData(rdData), .rdLast(rdLast)
  );

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;

  function automatic logic [15:0] arrayWord(input logic [AW-1:0] wa);
    logic [15:0] x;
    x = wa[15:0] ^ {11'd0, wa[20:16]};
    return x * 16'h9E37 + 16'h1234;
  endfunction

  function automatic logic [15:0] expBeat(input logic [AW-4:0] page, input bit byteMode,
                                          input int k);
    logic [3:0]  kk;
    logic [15:0] w;
    kk = 4'(k);
    if (byteMode) begin
      w = arrayWord({page, kk[3:1]});
      return {8'h00, kk[0] ? w[15:8] : w[7:0]};
    end
    return arrayWord({page, kk[2:0]});
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // ---------------- device model: poison data until the wait has elapsed
  logic [AW-1:0] mAddr = '0;
  logic          mAm1 = 1'b0;
  int            mAge = 0;
  logic          mSlow = 1'b1;
  logic          mFresh = 1'b1;

  always @(posedge clk) begin
    if (flashCeN || flashOeN) begin
      mFresh <= 1'b1; mAge <= 0; mSlow <= 1'b1;
    end else if (mFresh) begin
      mFresh <= 1'b0; mAge <= 1; mSlow <= 1'b1;
      mAddr <= flashAddr; mAm1 <= flashAm1;
    end else if (flashAddr != mAddr || flashAm1 != mAm1) begin
      mAge  <= 1;
      mSlow <= (flashAddr[AW-1:3] != mAddr[AW-1:3]);
      mAddr <= flashAddr; mAm1 <= flashAm1;
    end else if (mAge < 1000) begin
      mAge <= mAge + 1;
    end
  end

  always_comb begin
    logic [15:0] w;
    w = arrayWord(flashAddr);
    if (!flashCeN && !flashOeN && flashWeN && !mFresh && flashAddr == mAddr &&
        flashAm1 == mAm1 && mAge >= (mSlow ? FW - 1 : PW - 1))
      flashData = flashByteN ? w : {8'hEE, flashAm1 ? w[15:8] : w[7:0]};
    else
      flashData = 16'hBAD5;
  end

  // ---------------- scoreboard
  bit            burstOpen = 1'b0;
  bit            expByte   = 1'b0;
  logic [AW-4:0] expPage   = '0;
  int            beatK     = 0;
  int            acceptCyc = 0;
  bit            needGap   = 1'b0;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rstN && reqValid && reqReady) begin
      if (burstOpen) check(1'b0, "R7 request taken during burst", 1, 0);
      burstOpen = 1'b1;
      expPage   = reqAddr[AW:4];
      expByte   = reqByteMode;
      beatK     = 0;
      acceptCyc = cyc;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      check(flashWeN == 1'b1 && flashCeN == flashOeN, "R2 enables",
            {flashWeN, flashCeN, flashOeN}, {1'b1, flashCeN, flashCeN});
      if (needGap) begin
        check(flashCeN && flashOeN, "R8 gap after last", {flashCeN, flashOeN}, 2'b11);
        needGap = 1'b0;
      end
      if (burstOpen && !flashCeN) begin
        check(flashAddr[AW-1:3] == expPage, "R3 page address", flashAddr[AW-1:3], expPage);
        check(flashByteN == !expByte, expByte ? "R5 width pin" : "R4 width pin",
              flashByteN, !expByte);
      end
      if (rdValid) begin
        if (!burstOpen) begin
          check(1'b0, "R7 beat outside burst", 1, 0);
        end else begin
          check(rdData == expBeat(expPage, expByte, beatK), "R9 data",
                rdData, expBeat(expPage, expByte, beatK));
          check(cyc == acceptCyc + FW + beatK * PW, "R6 beat timing",
                cyc - acceptCyc, FW + beatK * PW);
          check(rdLast == (beatK == (expByte ? 15 : 7)), "R8 last flag",
                rdLast, beatK == (expByte ? 15 : 7));
          beatK++;
          if (rdLast) begin
            if (expByte) check(beatK == 16, "R5 beat count", beatK, 16);
            else         check(beatK == 8,  "R4 beat count", beatK, 8);
            burstOpen = 1'b0;
            needGap   = 1'b1;
          end
        end
      end
    end
  end

  // ---------------- driver
  task automatic runBurst(input logic [AW:0] addr, input bit byteMode, input bit holdBusy);
    reqValid    = 1'b1;
    reqAddr     = addr;
    reqByteMode = byteMode;
    @(posedge clk);
    while (!reqReady) @(posedge clk);
    @(negedge clk);
    if (holdBusy) begin
      // R7: keep requesting with different values while busy
      reqAddr     = ~addr;
      reqByteMode = ~byteMode;
    end else begin
      reqValid = 1'b0;
    end
    while (!rdLast) @(negedge clk);
    check(!reqReady, "R8 ready follows last", reqReady, 0);
    reqValid = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd715));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: idle state after reset
    check(reqReady && flashCeN && flashOeN && !rdValid && !rdLast, "R1 reset state",
          {reqReady, flashCeN, flashOeN, rdValid, rdLast}, 5'b11100);

    runBurst('0, 1'b0, 1'b0);                       // R4 word burst at page 0
    runBurst({(AW+1){1'b1}}, 1'b0, 1'b0);           // R3 top page, offset dropped
    runBurst(22'h12345, 1'b1, 1'b1);                // R5 misaligned byte start, R7 hold
    runBurst(22'h3FFFF0, 1'b1, 1'b0);               // back to back, R8 gap
    runBurst(22'h000017, 1'b0, 1'b1);               // R7 hold in word mode

    for (int i = 0; i < 40; i++) begin
      logic [AW:0] a;
      a = (AW+1)'($urandom);
      repeat ($urandom % 4) @(negedge clk);
      runBurst(a, 1'($urandom), 1'($urandom));
    end

    repeat (5) @(negedge clk);
    check(!burstOpen && reqReady, "R7 idle at end", {burstOpen, reqReady}, 2'b01);
    summary();
    $finish;
  end

endmodule